// File: doc/BRIEF.md
# Barrel Shifter with Shift-Opcode Decode

This block is the shift path of an ALU. It is purely combinational. It takes a 32-bit data word and an instruction word. The shift amount is the 5-bit field held in instruction bits 19 to 15. The output is the data word shifted left or right by 0 to 31 places. There are three kinds of shift: logical (fill with zeros), circular (rotate), and arithmetic right (fill with the sign bit). The shift runs through five cascaded stages that move 1, 2, 4, 8 and 16 places. Each stage is enabled by one bit of the count.

The four shift controls are enable, direction, circular and arithmetic. They come from one of two sources, chosen by `ctrl_src`:

- **Opcode decode** (`ctrl_src` = 0): the controls are decoded from the 5-bit opcode in instruction bits 31 to 27. Any opcode outside the shift group turns the shifter off, so the data passes through unchanged.
- **Direct ports** (`ctrl_src` = 1): the four controls are taken from external pins.

The circular control takes priority over the arithmetic control.

Inside the block, the four controls resolve to one of six named modes:

| Mode | Selected when |
|---|---|
| MODE_PASS | enable is low |
| MODE_LEFT_LOG | left, not circular (the arithmetic bit is ignored) |
| MODE_LEFT_ROT | left and circular |
| MODE_RIGHT_LOG | right, not circular, not arithmetic |
| MODE_RIGHT_ROT | right and circular (the arithmetic bit is ignored) |
| MODE_RIGHT_ARI | right, not circular, arithmetic |

There are no state transitions: the mode follows the inputs in the same cycle.

Top module: `bshift_top`

## Requirements
- R1: The data input and data output are 32 bits wide by default. The shift count is log2 of that width (5 bits).
- R2: The shift count is taken from instruction bits 19 to 15. No other instruction bit changes the shift amount.
- R3: With `ctrl_src` = 0, the opcode in instruction bits 31 to 27 selects the shift as follows:
  - 0x10: left logical
  - 0x11: left circular
  - 0x12: right logical
  - 0x13: right arithmetic
- R4: With `ctrl_src` = 0, any opcode other than 0x10 to 0x13 leaves the output equal to the input.
- R5: With `ctrl_src` = 1, the controls come from `ext_en`, `ext_left`, `ext_circ` and `ext_arith`. When `ext_en` = 0, the output equals the input.
- R6: The direction control selects a left shift when 1 and a right shift when 0.
- R7: When the circular control is 1, the shift is a rotate in the selected direction, whatever the arithmetic control is.
- R8: A right shift with circular = 0 and arithmetic = 1 fills the vacated high bits with input bit 31. A left shift with arithmetic = 1 fills with zeros.
- R9: Logical shifts fill the vacated bits with zeros.
- R10: A shift count of 0 returns the input unchanged in every mode.
- R11: The output depends only on the present inputs. There is no clock and no state, and the result is valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_word | input | 32 | Instruction word: opcode in bits 31:27, shift count in bits 19:15 |
| data_in | input | 32 | Word to be shifted |
| ctrl_src | input | 1 | 0 = controls decoded from the opcode, 1 = controls from the ext_* pins |
| ext_en | input | 1 | Direct shift enable |
| ext_left | input | 1 | Direct direction: 1 = left, 0 = right |
| ext_circ | input | 1 | Direct circular select |
| ext_arith | input | 1 | Direct arithmetic select (used only for a right, non-circular shift) |
| data_out | output | 32 | Shifted result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `data_out`. The bench changes the inputs on the falling clock edge and samples one nanosecond later, after the combinational logic has settled and well away from the next rising edge. Expected values come from two sources:

- a table of hand-worked vectors;
- a bit-by-bit reference model, which covers every opcode, every direct-control combination and every count from 0 to 31.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // Resolved shift behaviour; one encoding per distinct datapath setting.
    typedef enum logic [2:0] {
        MODE_PASS      = 3'd0,
        MODE_LEFT_LOG  = 3'd1,
        MODE_LEFT_ROT  = 3'd2,
        MODE_RIGHT_LOG = 3'd3,
        MODE_RIGHT_ROT = 3'd4,
        MODE_RIGHT_ARI = 3'd5
    } shift_mode_e;

    // Raw control bundle, as produced by the opcode decoder or the pins.
    typedef struct packed {
        logic en;
        logic left;
        logic circ;
        logic arith;
    } shift_ctl_t;

    // Opcode group holding the shift instructions (upper three opcode bits).
    localparam logic [2:0] SHIFT_GROUP = 3'b100;

    // Low two opcode bits inside the group.
    localparam logic [1:0] SUB_LEFT_LOG  = 2'b00;
    localparam logic [1:0] SUB_LEFT_ROT  = 2'b01;
    localparam logic [1:0] SUB_RIGHT_LOG = 2'b10;
    localparam logic [1:0] SUB_RIGHT_ARI = 2'b11;

endpackage

// File: rtl/bshift_opdec.sv
module bshift_opdec
    import bshift_pkg::*;
(
    input  logic [4:0] opcode,
    output shift_ctl_t ctl
);

    logic in_group;

    assign in_group = (opcode[4:2] == SHIFT_GROUP);

    always_comb begin
        ctl = '0;
        if (in_group) begin
            ctl.en = 1'b1;
            unique case (opcode[1:0])
                SUB_LEFT_LOG:  begin ctl.left = 1'b1; ctl.circ = 1'b0; ctl.arith = 1'b0; end
                SUB_LEFT_ROT:  begin ctl.left = 1'b1; ctl.circ = 1'b1; ctl.arith = 1'b0; end
                SUB_RIGHT_LOG: begin ctl.left = 1'b0; ctl.circ = 1'b0; ctl.arith = 1'b0; end
                SUB_RIGHT_ARI: begin ctl.left = 1'b0; ctl.circ = 1'b0; ctl.arith = 1'b1; end
            endcase
        end
    end

    // R3: a decoded shift never asks for circular and arithmetic together
    always_comb begin
        opdec_excl_chk: assert (!(ctl.circ && ctl.arith))
            else $error("opdec: circular and arithmetic both set");
    end

    // R4: outside the shift group every control stays low
    always_comb begin
        opdec_idle_chk: assert (in_group || (ctl == '0))
            else $error("opdec: controls active for non-shift opcode");
    end

endmodule

// File: rtl/bshift_mode.sv
module bshift_mode
    import bshift_pkg::*;
(
    input  shift_ctl_t  ctl,
    output shift_mode_e mode,
    output logic        go_left,
    output logic        rotate,
    output logic        sign_fill
);

    // Resolve the four controls: circular has priority over arithmetic,
    // and arithmetic only matters for a right shift.
    always_comb begin
        if (!ctl.en)
            mode = MODE_PASS;
        else if (ctl.left)
            mode = ctl.circ ? MODE_LEFT_ROT : MODE_LEFT_LOG;
        else if (ctl.circ)
            mode = MODE_RIGHT_ROT;
        else if (ctl.arith)
            mode = MODE_RIGHT_ARI;
        else
            mode = MODE_RIGHT_LOG;
    end

    // Datapath settings for each mode.
    always_comb begin
        go_left   = 1'b0;
        rotate    = 1'b0;
        sign_fill = 1'b0;
        unique case (mode)
            MODE_PASS:      ;
            MODE_LEFT_LOG:  go_left = 1'b1;
            MODE_LEFT_ROT:  begin go_left = 1'b1; rotate = 1'b1; end
            MODE_RIGHT_LOG: ;
            MODE_RIGHT_ROT: rotate = 1'b1;
            MODE_RIGHT_ARI: sign_fill = 1'b1;
            default:        ;
        endcase
    end

    // R7: a circular request always resolves to a rotate mode
    always_comb begin
        circ_wins_chk: assert (!(ctl.en && ctl.circ) ||
                               (mode == MODE_LEFT_ROT || mode == MODE_RIGHT_ROT))
            else $error("mode: circular request did not rotate");
    end

    // R8: sign fill only on a right, non-rotating shift
    always_comb begin
        sign_right_chk: assert (!sign_fill || (!go_left && !rotate))
            else $error("mode: sign fill outside right arithmetic");
    end

endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
    parameter int W    = 32,
    parameter int STEP = 1
) (
    input  logic [W-1:0] din,
    input  logic         active,
    input  logic         go_left,
    input  logic         rotate,
    input  logic         fill_bit,
    output logic [W-1:0] dout
);

    logic [STEP-1:0] left_in;
    logic [STEP-1:0] right_in;
    logic [W-1:0]    moved;

    // Bits entering at the low end on a left move, or at the high end on a right move.
    assign left_in  = rotate ? din[W-1 -: STEP] : {STEP{1'b0}};
    assign right_in = rotate ? din[STEP-1:0]    : {STEP{fill_bit}};

    always_comb begin
        if (go_left)
            moved = {din[W-1-STEP:0], left_in};
        else
            moved = {right_in, din[W-1:STEP]};
    end

    assign dout = active ? moved : din;

endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
#(
    parameter int W       = 32,
    parameter int IW      = 32,
    parameter int OP_LSB  = 27,
    parameter int CNT_LSB = 15
) (
    input  logic [IW-1:0] insn_word,
    input  logic [W-1:0]  data_in,
    input  logic          ctrl_src,
    input  logic          ext_en,
    input  logic          ext_left,
    input  logic          ext_circ,
    input  logic          ext_arith,
    output logic [W-1:0]  data_out
);

    localparam int CW     = $clog2(W);
    localparam int OP_W   = 5;
    localparam int OP_MSB = OP_LSB + OP_W - 1;
    localparam int CNT_MSB = CNT_LSB + CW - 1;

    logic [OP_W-1:0] opcode;
    logic [CW-1:0]   count;
    shift_ctl_t      dec_ctl;
    shift_ctl_t      pin_ctl;
    shift_ctl_t      sel_ctl;
    shift_mode_e     mode;
    logic            go_left;
    logic            rotate;
    logic            sign_fill;
    logic            fill_bit;
    logic [W-1:0]    stage_v [CW+1];
    logic            unused_insn_bits;

    assign opcode = insn_word[OP_MSB:OP_LSB];
    assign count  = insn_word[CNT_MSB:CNT_LSB];
    assign unused_insn_bits = ^{insn_word[OP_LSB-1:CNT_MSB+1], insn_word[CNT_LSB-1:0]};

    bshift_opdec u_opdec (
        .opcode (opcode),
        .ctl    (dec_ctl)
    );

    assign pin_ctl = '{en: ext_en, left: ext_left, circ: ext_circ, arith: ext_arith};
    assign sel_ctl = ctrl_src ? pin_ctl : dec_ctl;

    bshift_mode u_mode (
        .ctl       (sel_ctl),
        .mode      (mode),
        .go_left   (go_left),
        .rotate    (rotate),
        .sign_fill (sign_fill)
    );

    assign fill_bit = sign_fill & data_in[W-1];

    assign stage_v[0] = data_in;

    for (genvar k = 0; k < CW; k++) begin : g_stage
        bshift_stage #(
            .W    (W),
            .STEP (1 << k)
        ) u_stage (
            .din      (stage_v[k]),
            .active   ((mode != MODE_PASS) && count[k]),
            .go_left  (go_left),
            .rotate   (rotate),
            .fill_bit (fill_bit),
            .dout     (stage_v[k+1])
        );
    end

    assign data_out = stage_v[CW];

    // R5: a disabled shifter passes data untouched
    always_comb begin
        pass_thru_chk: assert ((mode != MODE_PASS) || (data_out == data_in))
            else $error("top: pass mode altered data");
    end

    // R10: zero count leaves data untouched in every mode
    always_comb begin
        zero_count_chk: assert ((count != '0) || (data_out == data_in))
            else $error("top: zero count altered data");
    end

    // R7: a rotate keeps the number of set bits
    always_comb begin
        rot_pop_chk: assert (!rotate || ($countones(data_out) == $countones(data_in)))
            else $error("top: rotate changed population");
    end

    // R8: right arithmetic keeps the sign bit
    always_comb begin
        sign_keep_chk: assert ((mode != MODE_RIGHT_ARI) || (data_out[W-1] == data_in[W-1]))
            else $error("top: arithmetic shift lost sign");
    end

    // R9: a left logical shift by a nonzero count clears bit 0
    always_comb begin
        left_zero_chk: assert ((mode != MODE_LEFT_LOG) || (count == '0) || !data_out[0])
            else $error("top: left logical shift filled a one");
    end

endmodule

// File: tb/test_bshift_top.sv
`timescale 1ns/1ps
module test_bshift_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] insn_word = '0;
    logic [31:0] data_in = '0;
    logic        ctrl_src = 1'b0;
    logic        ext_en = 1'b0;
    logic        ext_left = 1'b0;
    logic        ext_circ = 1'b0;
    logic        ext_arith = 1'b0;
    logic [31:0] data_out;

    int n_tests = 0;
    int n_fail  = 0;
    int wd_cnt  = 0;

    always #2.5 clk = ~clk;

    bshift_top i_bshift_top (
        .insn_word (insn_word),
        .data_in   (data_in),
        .ctrl_src  (ctrl_src),
        .ext_en    (ext_en),
        .ext_left  (ext_left),
        .ext_circ  (ext_circ),
        .ext_arith (ext_arith),
        .data_out  (data_out)
    );

    // Vector: {insn, data, expected}, all via opcode decode.
    localparam logic [95:0] VEC [11] = '{
        {32'h8002_0000, 32'h8000_0001, 32'h0000_0010},  // R3 R9 left logical 4
        {32'h8802_0000, 32'h8000_0001, 32'h0000_0018},  // R3 R7 left circular 4
        {32'h9002_0000, 32'h8000_0001, 32'h0800_0000},  // R3 R9 right logical 4
        {32'h9802_0000, 32'h8000_0001, 32'hF800_0000},  // R3 R8 right arithmetic 4
        {32'h980F_8000, 32'h8000_0000, 32'hFFFF_FFFF},  // R8 count 31
        {32'h800F_8000, 32'h0000_0003, 32'h8000_0000},  // R9 count 31
        {32'h8800_0000, 32'h1234_5678, 32'h1234_5678},  // R10 count 0
        {32'hA802_0000, 32'h1234_5678, 32'h1234_5678},  // R4 opcode 0x15
        {32'h9008_0000, 32'hABCD_1234, 32'h0000_ABCD},  // R2 count 16
        {32'h9804_0000, 32'h7F00_00FF, 32'h007F_0000},  // R8 positive sign
        {32'h8808_0000, 32'hABCD_1234, 32'h1234_ABCD}   // R7 rotate 16
    };

    function automatic logic [31:0] ref_shift(input logic [31:0] d, input int cnt,
                                              input logic en, input logic lft,
                                              input logic circ, input logic ari);
        logic [31:0] r;
        if (!en) return d;
        for (int i = 0; i < 32; i++) begin
            int src;
            if (lft) begin
                src = i - cnt;
                r[i] = (src >= 0) ? d[src] : (circ ? d[src+32] : 1'b0);
            end else begin
                src = i + cnt;
                r[i] = (src < 32) ? d[src] : (circ ? d[src-32] : (ari ? d[31] : 1'b0));
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] exp);
        n_tests++;
        if (data_out !== exp) begin
            n_fail++;
            $display("FAIL %s: insn=%h data=%h got=%h expected=%h",
                     req, insn_word, data_in, data_out, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] d);
        @(negedge clk);
        insn_word = ins;
        data_in   = d;
        #1;
    endtask

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 100000) begin
            n_fail++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] PATS [3] = '{32'h8000_0001, 32'hA5C3_0F96, 32'h7FFF_FFFE};

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 idle output", 32'h0);

        // R1 R3: hand-worked vector table
        for (int v = 0; v < 11; v++) begin
            apply(VEC[v][95:64], VEC[v][63:32]);
            check("R3 vector", VEC[v][31:0]);
        end

        // R2: unrelated instruction bits do not change the count
        apply(32'h8002_0000 | 32'h07F0_7FFF & ~32'h000F_8000, 32'h8000_0001);
        check("R2 field isolation", 32'h0000_0010);

        // R3 R10: every shift opcode, every count
        for (int op = 0; op < 4; op++) begin
            for (int c = 0; c < 32; c++) begin
                for (int p = 0; p < 3; p++) begin
                    logic lft;
                    logic cir;
                    logic ari;
                    lft = (op < 2);
                    cir = (op == 1);
                    ari = (op == 3);
                    apply(((32'h10 + op) << 27) | (c << 15), PATS[p]);
                    check((c == 0) ? "R10 zero count" : "R3 opcode sweep",
                          ref_shift(PATS[p], c, 1'b1, lft, cir, ari));
                end
            end
        end

        // R4: non-shift opcodes pass through
        for (int op = 0; op < 32; op++) begin
            if (op < 16 || op > 19) begin
                apply((op << 27) | (32'd7 << 15), 32'hA5C3_0F96);
                check("R4 non-shift opcode", 32'hA5C3_0F96);
            end
        end

        // R5 R6 R7 R8 R9: direct controls, all combinations
        ctrl_src = 1'b1;
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < 32; c += 3) begin
                ext_en = k[3]; ext_left = k[2]; ext_circ = k[1]; ext_arith = k[0];
                apply(32'hA800_0000 | (c << 15), 32'h9000_00F1);
                check(!k[3] ? "R5 disabled" : (k[1] ? "R7 circular wins" :
                      (k[0] ? "R8 arith" : "R6 direction")),
                      ref_shift(32'h9000_00F1, c, k[3], k[2], k[1], k[0]));
            end
        end

        // R7: circular overrides arithmetic on a right shift
        ext_en = 1; ext_left = 0; ext_circ = 1; ext_arith = 1;
        apply(32'h0000_8000, 32'h8000_0001);
        check("R7 override", 32'hC000_0000);

        // R8: left with arith set fills with zeros
        ext_en = 1; ext_left = 1; ext_circ = 0; ext_arith = 1;
        apply(32'h0001_0000, 32'hFFFF_FFFF);
        check("R8 left arith zeros", 32'hFFFF_FFFC);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule